// File: doc/BRIEF.md
# Pedestal-Levelled Line Peak Finder

This block takes a line-scan sensor's pixel stream after calibration, two samples per beat (an even-indexed and an odd-indexed pixel). It reads each pair's pedestal values from an external memory that has one cycle of read latency. It then raises every pixel to a shared baseline, so one threshold serves the whole line. At the end of each line it knows the single brightest levelled pixel. If that pixel is above the threshold, the block emits one event with a found bit, the pixel position, the amplitude and the number of the line.

The pixel input uses valid/ready. A pair is taken on a clock edge where `pix_valid`, `pix_ready` and `line_valid` are all high. The source must hold the pair stable until it is taken. `pix_ready` is low while the block is disabled and while an event waits at the output. The event output also uses valid/ready. Once `evt_valid` rises, it and all event fields stay unchanged until the edge where `evt_ready` is high. Control inputs (`en`, the maximum pedestal, the margin and the threshold) are plain levels.

Top module: `pl_peak_finder`

## Requirements
- R1: While `en` is low, `pix_ready` is low, no pair is taken and no event or line number results from that traffic.
- R2: Each sample is levelled as corr = raw + (max_ped + margin − ped). The added term is clamped at zero when ped exceeds max_ped + margin, and the result saturates at 4095.
- R3: In pair k (counted from 0 within the line), the even sample is pixel 2k and the odd sample is pixel 2k+1. `evt_pos` is the index of the largest levelled sample. On a tie, the lower index wins.
- R4: `evt_amp` equals the largest levelled sample of the line.
- R5: An event is produced only when that largest value is strictly greater than `threshold`, and `evt_found` is 1 on every event.
- R6: `evt_valid` rises on the second clock edge after the first edge that samples `line_valid` low. It then holds with stable fields until accepted with `evt_ready`.
- R7: Only a line of exactly 256 taken pairs is complete. Complete lines are numbered 0, 1, 2, … from reset, and `evt_ts` carries that number. A complete line advances the number whether or not it yields an event. Shorter or longer lines are ignored and do not advance it.
- R8: `ped_addr` shows the index of the pair being offered on the edge that takes it. The matching pedestal data is expected on `ped_even`/`ped_odd` during the following cycle.
- R9: While an event waits unaccepted, `pix_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Calibration finished; block may take pixels |
| line_valid | input | 1 | High for the duration of one sensor line |
| pix_valid | input | 1 | Pixel pair offered |
| pix_ready | output | 1 | Pixel pair can be taken |
| pix_even | input | 12 | Even-indexed raw sample |
| pix_odd | input | 12 | Odd-indexed raw sample |
| ped_addr | output | 8 | Pedestal memory read address (pair index) |
| ped_even | input | 12 | Pedestal of the even sample, one cycle after address |
| ped_odd | input | 12 | Pedestal of the odd sample, one cycle after address |
| max_ped | input | 12 | Largest pedestal in the memory |
| margin | input | 12 | Extra lift above the largest pedestal |
| threshold | input | 12 | Presence threshold on levelled amplitude |
| evt_valid | output | 1 | Event available |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_found | output | 1 | Object-found flag |
| evt_pos | output | 9 | Pixel index of the peak |
| evt_amp | output | 12 | Levelled peak amplitude |
| evt_ts | output | 44 | Complete-line number |

## Verification
Random lines with random pedestals and gaps in the pixel stream show that levelling and peak search agree with a reference model, wherever the peak happens to fall. Directed lines separate the corner cases. Flat lines and equal even/odd maxima test the lower-index tie rule. Samples near full scale test saturation. A pedestal above the lift level tests the zero clamp. An amplitude equal to the threshold tests the strict comparison. Lines of 100 and 257 pairs, disabled traffic, and an event held under back-pressure show that the line count advances only on complete lines and that input is stalled while an event waits.

// File: rtl/pl_pkg.sv
package pl_pkg;
  localparam int PIX_W   = 12;
  localparam int PAIRS   = 256;
  localparam int LANES   = 2;
  localparam int TS_W    = 44;
  localparam int PAIR_W  = $clog2(PAIRS);
  localparam int POS_W   = $clog2(PAIRS * LANES);
  localparam int CNT_W   = $clog2(PAIRS + 2);
  localparam int LVL_W   = PIX_W + 1;
  localparam int SUM_W   = PIX_W + 2;
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    logic             found;
    logic [POS_W-1:0] pos;
    pix_t             amp;
    logic [TS_W-1:0]  ts;
  } evt_t;
endpackage

// File: rtl/pl_lift.sv
module pl_lift
  import pl_pkg::*;
(
  input  pix_t             raw,
  input  pix_t             ped,
  input  logic [LVL_W-1:0] level,
  output pix_t             corr
);
  logic [SUM_W-1:0] lift;
  logic [SUM_W-1:0] total;

  always_comb begin
    lift  = (level >= {1'b0, ped}) ? SUM_W'(level - {1'b0, ped}) : '0;
    total = SUM_W'(raw) + lift;
    corr  = (total > SUM_W'(PIX_MAX)) ? pix_t'(PIX_MAX) : total[PIX_W-1:0];
  end
endmodule

// File: rtl/pl_peak.sv
module pl_peak
  import pl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              first,
  input  logic [PAIR_W-1:0] pair,
  input  pix_t              c_even,
  input  pix_t              c_odd,
  output pix_t              best_amp,
  output logic [POS_W-1:0]  best_pos
);
  logic             odd_wins;
  pix_t             cand_amp;
  logic [POS_W-1:0] cand_pos;

  always_comb begin
    odd_wins = c_odd > c_even;
    cand_amp = odd_wins ? c_odd : c_even;
    cand_pos = {pair, odd_wins};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_amp <= '0;
      best_pos <= '0;
    end else if (upd && (first || cand_amp > best_amp)) begin
      best_amp <= cand_amp;
      best_pos <= cand_pos;
    end
  end

  // R4: within a line the running peak never decreases
  p_peak_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !first) |=> best_amp >= $past(best_amp));
endmodule

// File: rtl/pl_linectl.sv
module pl_linectl
  import pl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lval,
  input  logic              acc,
  output logic [PAIR_W-1:0] pair_idx,
  output logic              done,
  output logic [TS_W-1:0]   ts
);
  logic             lval_q;
  logic             end_now;
  logic [CNT_W-1:0] cnt;

  assign end_now  = lval_q && !lval;
  assign pair_idx = cnt[PAIR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lval_q <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
      ts     <= '0;
    end else begin
      lval_q <= lval;
      done   <= end_now && (cnt == CNT_W'(PAIRS));
      if (end_now)
        cnt <= '0;
      else if (acc && cnt != CNT_W'(PAIRS + 1))
        cnt <= cnt + 1'b1;
      if (done)
        ts <= ts + 1'b1;
    end
  end

  // R7: line number moves by exactly one per complete line and otherwise holds
  p_ts_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ts == $past(ts) + 1'b1);
  p_ts_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(ts));
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PAIRS + 1));
endmodule

// File: rtl/pl_peak_finder.sv
module pl_peak_finder
  import pl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              line_valid,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [PIX_W-1:0]  pix_even,
  input  logic [PIX_W-1:0]  pix_odd,
  output logic [PAIR_W-1:0] ped_addr,
  input  logic [PIX_W-1:0]  ped_even,
  input  logic [PIX_W-1:0]  ped_odd,
  input  logic [PIX_W-1:0]  max_ped,
  input  logic [PIX_W-1:0]  margin,
  input  logic [PIX_W-1:0]  threshold,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic              evt_found,
  output logic [POS_W-1:0]  evt_pos,
  output logic [PIX_W-1:0]  evt_amp,
  output logic [TS_W-1:0]   evt_ts
);
  logic              acc;
  logic              s1_v;
  pix_t              s1_raw [LANES];
  logic [PAIR_W-1:0] s1_pair;
  pix_t              ped_l  [LANES];
  pix_t              corr_l [LANES];
  logic [LVL_W-1:0]  level;
  logic              done;
  logic [TS_W-1:0]   ts;
  pix_t              best_amp;
  logic [POS_W-1:0]  best_pos;
  evt_t              evt_q;
  logic              evt_v_q;

  assign pix_ready = en && !evt_v_q;
  assign acc       = pix_valid && pix_ready && line_valid;
  assign level     = {1'b0, max_ped} + {1'b0, margin};
  assign ped_l[0]  = ped_even;
  assign ped_l[1]  = ped_odd;

  // stage 1: capture the pair while the pedestal read is in flight
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_pair <= '0;
      for (int i = 0; i < LANES; i++) s1_raw[i] <= '0;
    end else begin
      s1_v <= acc;
      if (acc) begin
        s1_raw[0] <= pix_even;
        s1_raw[1] <= pix_odd;
        s1_pair   <= ped_addr;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pl_lift u_lift (
      .raw   (s1_raw[g]),
      .ped   (ped_l[g]),
      .level (level),
      .corr  (corr_l[g])
    );
  end

  pl_peak u_peak (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (s1_v),
    .first    (s1_pair == '0),
    .pair     (s1_pair),
    .c_even   (corr_l[0]),
    .c_odd    (corr_l[1]),
    .best_amp (best_amp),
    .best_pos (best_pos)
  );

  pl_linectl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .lval     (line_valid),
    .acc      (acc),
    .pair_idx (ped_addr),
    .done     (done),
    .ts       (ts)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_v_q <= 1'b0;
      evt_q   <= '0;
    end else begin
      if (evt_v_q && evt_ready)
        evt_v_q <= 1'b0;
      if (done && best_amp > threshold) begin
        evt_v_q     <= 1'b1;
        evt_q.found <= 1'b1;
        evt_q.pos   <= best_pos;
        evt_q.amp   <= best_amp;
        evt_q.ts    <= ts;
      end
    end
  end

  assign evt_valid = evt_v_q;
  assign evt_found = evt_q.found;
  assign evt_pos   = evt_q.pos;
  assign evt_amp   = evt_q.amp;
  assign evt_ts    = evt_q.ts;

  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pix_ready);
  // R2: levelling never lowers a sample
  p_lift_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> (corr_l[0] >= s1_raw[0]) && (corr_l[1] >= s1_raw[1]));
  p_above_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> (evt_amp > $past(threshold)) && evt_found);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> evt_valid && $stable(evt_pos)
                                   && $stable(evt_amp) && $stable(evt_ts));
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> !pix_ready);
endmodule

// File: tb/pl_peak_finder_tb_top.sv
module pl_peak_finder_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n, en, line_valid, pix_valid, pix_ready;
  logic [11:0] pix_even, pix_odd, ped_even, ped_odd, max_ped, margin, threshold;
  logic [7:0]  ped_addr;
  logic        evt_valid, evt_ready, evt_found;
  logic [8:0]  evt_pos;
  logic [11:0] evt_amp;
  logic [43:0] evt_ts;

  logic [11:0] pm_e [256];
  logic [11:0] pm_o [256];
  logic [11:0] re [256];
  logic [11:0] ro [256];

  int n_chk = 0, n_fail = 0, ev_n = 0;
  logic        prev_v = 1'b0;
  logic [8:0]  ev_pos;
  logic [11:0] ev_amp;
  logic [43:0] ev_ts;
  logic        ev_found;
  longint      exp_ts = 0;
  bit          addr_bad;

  always #(CLK_P/2) clk = ~clk;

  pl_peak_finder dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .line_valid(line_valid),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_even(pix_even),
    .pix_odd(pix_odd), .ped_addr(ped_addr), .ped_even(ped_even),
    .ped_odd(ped_odd), .max_ped(max_ped), .margin(margin),
    .threshold(threshold), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_found(evt_found), .evt_pos(evt_pos), .evt_amp(evt_amp),
    .evt_ts(evt_ts)
  );

  // pedestal memory with one cycle read latency
  always @(posedge clk) begin
    ped_even <= pm_e[ped_addr];
    ped_odd  <= pm_o[ped_addr];
  end

  // event monitor: one record per rising evt_valid, sampled at negedge
  always @(negedge clk) begin
    if (evt_valid && !prev_v) begin
      ev_n++;
      ev_pos = evt_pos; ev_amp = evt_amp; ev_ts = evt_ts; ev_found = evt_found;
    end
    prev_v <= evt_valid;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lvl(input logic [11:0] raw, input logic [11:0] ped);
    int lv = int'(max_ped) + int'(margin);
    int lift = (lv > int'(ped)) ? lv - int'(ped) : 0;
    int t = int'(raw) + lift;
    return (t > 4095) ? 4095 : t;
  endfunction

  task automatic model(output int amp, output int pos);
    amp = -1; pos = 0;
    for (int k = 0; k < 256; k++) begin
      int a = lvl(re[k], pm_e[k]);
      int b = lvl(ro[k], pm_o[k]);
      if (a > amp) begin amp = a; pos = 2*k; end
      if (b > amp) begin amp = b; pos = 2*k + 1; end
    end
  endtask

  task automatic drive_line(input int n, input int gapmax);
    bit rdy;
    addr_bad = 0;
    @(negedge clk);
    line_valid = 1'b1;
    for (int k = 0; k < n; k++) begin
      int gap = (gapmax > 0) ? int'($urandom_range(gapmax)) : 0;
      for (int g = 0; g < gap; g++) begin
        pix_valid = 1'b0;
        @(negedge clk);
      end
      pix_valid = 1'b1;
      pix_even  = re[k % 256];
      pix_odd   = ro[k % 256];
      forever begin
        rdy = pix_ready;
        if (rdy && ped_addr != 8'(k % 256)) addr_bad = 1;
        @(negedge clk);
        if (rdy) break;
      end
    end
    pix_valid  = 1'b0;
    line_valid = 1'b0;
  endtask

  task automatic line_check(input int n, input int gapmax, input string tag);
    int amp, pos, ev0;
    bit want, v1, v2;
    ev0 = ev_n;
    drive_line(n, gapmax);
    model(amp, pos);
    @(negedge clk); v1 = evt_valid;
    @(negedge clk); v2 = evt_valid;
    repeat (3) @(negedge clk);
    want = (n == 256) && (amp > int'(threshold));
    chk(!addr_bad, "R8", {tag, " pedestal address"}, addr_bad, 0);
    chk((ev_n - ev0) == int'(want), "R5", {tag, " event count"}, ev_n - ev0, want);
    if (want) begin
      chk(!v1 && v2, "R6", {tag, " event timing"}, {v1, v2}, 2'b01);
      chk(ev_pos == 9'(pos), "R3", {tag, " position"}, ev_pos, pos);
      chk(ev_amp == 12'(amp), "R4", {tag, " amplitude"}, ev_amp, amp);
      chk(ev_ts == 44'(exp_ts), "R7", {tag, " line number"}, ev_ts, exp_ts);
      chk(ev_found, "R5", {tag, " found flag"}, ev_found, 1);
    end
    if (n == 256) exp_ts++;
  endtask

  task automatic fill_random();
    for (int k = 0; k < 256; k++) begin
      pm_e[k] = 12'($urandom_range(600));
      pm_o[k] = 12'($urandom_range(600));
      re[k]   = 12'($urandom_range(1500));
      ro[k]   = 12'($urandom_range(1500));
    end
    max_ped = 12'd600;
  endtask

  task automatic fill_flat(input logic [11:0] r, input logic [11:0] p);
    for (int k = 0; k < 256; k++) begin
      pm_e[k] = p; pm_o[k] = p; re[k] = r; ro[k] = r;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int amp, pos;
    void'($urandom(32'd4242));
    rst_n = 1'b0; en = 1'b0; line_valid = 1'b0; pix_valid = 1'b0;
    pix_even = '0; pix_odd = '0; evt_ready = 1'b1;
    max_ped = '0; margin = 12'd50; threshold = 12'd100;
    fill_flat(12'd0, 12'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pix_ready, "R1", "reset disabled ready", pix_ready, 0);
    chk(!evt_valid, "R6", "reset event valid", evt_valid, 0);

    // R1: traffic while disabled is ignored
    fill_random();
    @(negedge clk);
    line_valid = 1'b1; pix_valid = 1'b1;
    repeat (300) @(negedge clk);
    line_valid = 1'b0; pix_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(ev_n == 0, "R1", "no event while disabled", ev_n, 0);
    en = 1'b1;
    @(negedge clk);
    chk(pix_ready, "R1", "ready once enabled", pix_ready, 1);

    // random lines: R2 R3 R4 R7
    for (int i = 0; i < 6; i++) begin
      fill_random();
      margin = 12'($urandom_range(200));
      threshold = 12'd200;
      line_check(256, 2, "random");
    end

    // R3 flat line: tie goes to pixel 0
    fill_flat(12'd1000, 12'd300); max_ped = 12'd300; margin = 12'd20;
    line_check(256, 0, "flat tie");
    chk(ev_pos == 0 && ev_amp == 12'd1020, "R3", "flat tie pos", ev_pos, 0);

    // R3 even/odd tie and odd-only peak
    fill_flat(12'd100, 12'd0); max_ped = 12'd0; margin = 12'd0;
    re[5] = 12'd3000; ro[5] = 12'd3000; ro[7] = 12'd2000;
    line_check(256, 1, "pair tie");
    chk(ev_pos == 9'd10, "R3", "even wins tie", ev_pos, 10);
    re[5] = 12'd10; ro[5] = 12'd10;
    line_check(256, 1, "odd peak");
    chk(ev_pos == 9'd15, "R3", "odd index", ev_pos, 15);

    // R2 saturation
    fill_flat(12'd500, 12'd0); margin = 12'd100;
    ro[16] = 12'd4090; re[20] = 12'd4080;
    line_check(256, 0, "saturate");
    chk(ev_amp == 12'd4095 && ev_pos == 9'd33, "R2", "saturated peak", ev_amp, 4095);

    // R2 clamp: pedestal above lift level adds nothing
    fill_flat(12'd100, 12'd0); max_ped = 12'd10; margin = 12'd0;
    pm_e[40] = 12'd900; re[40] = 12'd700;
    line_check(256, 0, "clamp");
    chk(ev_amp == 12'd700 && ev_pos == 9'd80, "R2", "clamped lift", ev_amp, 700);

    // R5 amplitude equal to threshold: no event, R7 number still moves
    model(amp, pos);
    threshold = 12'(amp);
    line_check(256, 0, "thr equal");
    threshold = 12'(amp - 1);
    line_check(256, 0, "thr below");

    // R7 short and long lines are ignored
    threshold = 12'd0;
    line_check(100, 1, "short");
    line_check(257, 0, "long");
    line_check(256, 0, "after odd lengths");

    // R6 R9 back-pressure
    evt_ready = 1'b0;
    fill_random(); margin = 12'd10; threshold = 12'd0;
    model(amp, pos);
    drive_line(256, 0);
    repeat (6) @(negedge clk);
    chk(evt_valid, "R6", "event held", evt_valid, 1);
    chk(evt_amp == 12'(amp) && evt_pos == 9'(pos), "R6", "held fields", evt_amp, amp);
    chk(!pix_ready, "R9", "input stalled", pix_ready, 0);
    evt_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!evt_valid, "R6", "accepted", evt_valid, 0);
    chk(pix_ready, "R9", "input resumes", pix_ready, 1);
    exp_ts++;
    fill_random(); threshold = 12'd0;
    line_check(256, 1, "post stall");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule